// File: doc/BRIEF.md
# Stage Interrupt and GPIO Controller

This block gathers per-stage events from a twelve-stage capacitance conversion sequencer and turns them into one interrupt line. Three event classes arrive on separate input vectors: a stage's low limit is currently exceeded, a stage's high limit is currently exceeded, and a stage has just finished converting. Each class latches into a sticky status register, and each class has its own enable mask. The interrupt output is the OR of every enabled, set status bit. A control bit selects whether that output is active high or active low.

A single general-purpose pin shares the block. It can be switched off, used as an input, or driven low or high. In input mode it can raise the interrupt on a chosen level. That level passes through a two-flop synchronizer first, and it latches into its own sticky status bit.

A host reaches the block through a simple strobe-based register port. Reads are combinational. Reading a status register clears it on the clock edge that ends the read cycle. A bit whose event is still present in that same cycle stays set.

Top module: `stint_irq_ctrl`

## Requirements
- R1: After reset, every enable mask, status bit and control field is 0. With polarity 0 the interrupt output therefore rests high, and the pin is not driven (`gpio_oe` = 0).
- R2: Register addresses 1, 2 and 3 hold the low-limit, high-limit and completion enable masks. Each mask is written from `reg_wdata[11:0]`, and bits 15:12 always read back as 0.
- R3: A low-limit or high-limit status bit (address 4 or 5, bit n = stage n) is set at the clock edge where the matching `lim_low`/`lim_high` bit is 1. It stays set until its register is read.
- R4: A read of address 4 or 5 clears, at the following edge, every bit whose limit input is 0 in the read cycle. A bit whose limit is still 1 remains set.
- R5: A completion status bit (address 6) is set by a one-cycle `conv_done` pulse and is cleared by a read of address 6. A pulse arriving in the read cycle itself leaves its bit set.
- R6: The interrupt is pending exactly when some status bit is set together with its enable bit, or when the pin status bit is set. A cleared enable bit blocks the interrupt but still lets the status bit latch.
- R7: Control bit 0 (address 0) gives the polarity. With 0, a pending interrupt drives `int_out` low and an idle one drives it high. With 1, the levels are reversed.
- R8: The pin mode sits in control bits 3:2. Code 0 means off, 1 means input, 2 means driven low and 3 means driven high. `gpio_oe` is 1 only for codes 2 and 3, and `gpio_out` is 1 only for code 3.
- R9: In input mode, control bits 5:4 pick the trigger. Code 1 triggers on a high level, code 2 on a low level, and codes 0 and 3 never trigger. The synchronized level sets status bit 0 at address 7, which takes effect within three clock edges of a pad change. A read of address 7 clears that bit unless the trigger level is still present.
- R10: Control register reads return polarity in bit 0, mode in bits 3:2 and trigger in bits 5:4, with every other bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lim_low | input | 12 | Per-stage flag: low limit exceeded now |
| lim_high | input | 12 | Per-stage flag: high limit exceeded now |
| conv_done | input | 12 | Per-stage one-cycle conversion-finished pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears status registers) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data, combinational from the address |
| gpio_in | input | 1 | Pad level, asynchronous |
| gpio_oe | output | 1 | Pad output enable |
| gpio_out | output | 1 | Pad output level |
| int_out | output | 1 | Interrupt line, programmable polarity |

## Verification
The assertions assume that `reg_rd` and `reg_wr` are never high in the same cycle. They also assume that `reg_addr`, `reg_rd`, `reg_wr` and the event vectors are stable around the sampling edge, and that the pad input may change at any time. The stimulus meets these assumptions: it changes every input only on the falling clock edge, issues each access as an isolated one-cycle strobe, and holds limit levels across reads wherever the "still exceeded" behaviour is under test. Pad checks wait four cycles after each pad change, which covers the synchronizer latency.

// File: rtl/stint_pkg.sv
package stint_pkg;

    localparam int REG_AW = 3;
    localparam int NCLASS = 3;   // low limit, high limit, completion

    typedef enum logic [REG_AW-1:0] {
        ADDR_CTRL    = 3'd0,
        ADDR_LOW_EN  = 3'd1,
        ADDR_HIGH_EN = 3'd2,
        ADDR_DONE_EN = 3'd3,
        ADDR_LOW_ST  = 3'd4,
        ADDR_HIGH_ST = 3'd5,
        ADDR_DONE_ST = 3'd6,
        ADDR_GPIO_ST = 3'd7
    } reg_addr_e;

    typedef enum logic [1:0] {
        GPIO_OFF  = 2'd0,
        GPIO_IN   = 2'd1,
        GPIO_DRV0 = 2'd2,
        GPIO_DRV1 = 2'd3
    } gpio_mode_e;

    typedef enum logic [1:0] {
        TRIG_NONE  = 2'd0,
        TRIG_HIGH  = 2'd1,
        TRIG_LOW   = 2'd2,
        TRIG_NONE2 = 2'd3
    } gpio_trig_e;

    typedef struct packed {
        gpio_trig_e trig;
        gpio_mode_e mode;
        logic       pol;
    } ctrl_t;

endpackage

// File: rtl/stint_cfg_regs.sv
module stint_cfg_regs
    import stint_pkg::*;
#(
    parameter int NSTAGE = 12,
    parameter int DW     = 16
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic [REG_AW-1:0]              addr,
    input  logic [DW-1:0]                  wdata,
    output ctrl_t                          ctrl_o,
    output logic [NCLASS-1:0][NSTAGE-1:0]  en_o
);

    typedef struct packed {
        ctrl_t                          ctrl;
        logic [NCLASS-1:0][NSTAGE-1:0]  en;
    } cfg_state_t;

    cfg_state_t s_d, s_q;

    logic unused_wdata;
    assign unused_wdata = ^wdata[DW-1:NSTAGE];

    always_comb begin
        s_d = s_q;
        if (wr_en) begin
            case (addr)
                ADDR_CTRL: begin
                    s_d.ctrl.pol  = wdata[0];
                    s_d.ctrl.mode = gpio_mode_e'(wdata[3:2]);
                    s_d.ctrl.trig = gpio_trig_e'(wdata[5:4]);
                end
                ADDR_LOW_EN:  s_d.en[0] = wdata[NSTAGE-1:0];
                ADDR_HIGH_EN: s_d.en[1] = wdata[NSTAGE-1:0];
                ADDR_DONE_EN: s_d.en[2] = wdata[NSTAGE-1:0];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign ctrl_o = s_q.ctrl;
    assign en_o   = s_q.en;

endmodule

// File: rtl/stint_sticky.sv
module stint_sticky #(
    parameter int W = 12
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set_i,
    input  logic         clr_i,
    output logic [W-1:0] stat_o
);

    logic [W-1:0] stat_d, stat_q;

    // A clearing read drops old bits; an event in the same cycle sets anew.
    always_comb begin
        stat_d = (clr_i ? '0 : stat_q) | set_i;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stat_q <= '0;
        else        stat_q <= stat_d;
    end

    assign stat_o = stat_q;

endmodule

// File: rtl/stint_gpio.sv
module stint_gpio
    import stint_pkg::*;
#(
    parameter int SYNC_DEPTH = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pad_i,
    input  gpio_mode_e mode_i,
    input  gpio_trig_e trig_i,
    output logic       oe_o,
    output logic       out_o,
    output logic       hit_o
);

    logic [SYNC_DEPTH-1:0] sync_d, sync_q;
    logic                  lvl;

    generate
        if (SYNC_DEPTH == 1) begin : g_one
            always_comb sync_d = pad_i;
        end else begin : g_chain
            always_comb sync_d = {sync_q[SYNC_DEPTH-2:0], pad_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= sync_d;
    end

    assign lvl = sync_q[SYNC_DEPTH-1];

    always_comb begin
        hit_o = 1'b0;
        if (mode_i == GPIO_IN) begin
            case (trig_i)
                TRIG_HIGH: hit_o = lvl;
                TRIG_LOW:  hit_o = ~lvl;
                default:   hit_o = 1'b0;
            endcase
        end
        oe_o  = (mode_i == GPIO_DRV0) || (mode_i == GPIO_DRV1);
        out_o = (mode_i == GPIO_DRV1);
    end

endmodule

// File: rtl/stint_irq_ctrl.sv
module stint_irq_ctrl
    import stint_pkg::*;
#(
    parameter int NSTAGE     = 12,
    parameter int DW         = 16,
    parameter int SYNC_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NSTAGE-1:0]    lim_low,
    input  logic [NSTAGE-1:0]    lim_high,
    input  logic [NSTAGE-1:0]    conv_done,
    input  logic                 reg_wr,
    input  logic                 reg_rd,
    input  logic [REG_AW-1:0]    reg_addr,
    input  logic [DW-1:0]        reg_wdata,
    output logic [DW-1:0]        reg_rdata,
    input  logic                 gpio_in,
    output logic                 gpio_oe,
    output logic                 gpio_out,
    output logic                 int_out
);

    ctrl_t                          ctrl;
    logic [NCLASS-1:0][NSTAGE-1:0]  en;
    logic [NCLASS-1:0][NSTAGE-1:0]  evt;
    logic [NCLASS-1:0][NSTAGE-1:0]  stat;
    logic                           gpio_hit;
    logic                           gpio_stat;
    logic                           pending;

    assign evt[0] = lim_low;
    assign evt[1] = lim_high;
    assign evt[2] = conv_done;

    stint_cfg_regs #(.NSTAGE(NSTAGE), .DW(DW)) u_cfg (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (reg_wr),
        .addr   (reg_addr),
        .wdata  (reg_wdata),
        .ctrl_o (ctrl),
        .en_o   (en)
    );

    generate
        for (genvar c = 0; c < NCLASS; c++) begin : g_cls
            localparam logic [REG_AW-1:0] ST_ADDR = REG_AW'(int'(ADDR_LOW_ST) + c);
            stint_sticky #(.W(NSTAGE)) u_st (
                .clk    (clk),
                .rst_n  (rst_n),
                .set_i  (evt[c]),
                .clr_i  (reg_rd && (reg_addr == ST_ADDR)),
                .stat_o (stat[c])
            );
        end
    endgenerate

    stint_gpio #(.SYNC_DEPTH(SYNC_DEPTH)) u_gpio (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_i  (gpio_in),
        .mode_i (ctrl.mode),
        .trig_i (ctrl.trig),
        .oe_o   (gpio_oe),
        .out_o  (gpio_out),
        .hit_o  (gpio_hit)
    );

    stint_sticky #(.W(1)) u_gst (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_i  (gpio_hit),
        .clr_i  (reg_rd && (reg_addr == ADDR_GPIO_ST)),
        .stat_o (gpio_stat)
    );

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_CTRL: begin
                reg_rdata[0]   = ctrl.pol;
                reg_rdata[3:2] = ctrl.mode;
                reg_rdata[5:4] = ctrl.trig;
            end
            ADDR_LOW_EN:  reg_rdata[NSTAGE-1:0] = en[0];
            ADDR_HIGH_EN: reg_rdata[NSTAGE-1:0] = en[1];
            ADDR_DONE_EN: reg_rdata[NSTAGE-1:0] = en[2];
            ADDR_LOW_ST:  reg_rdata[NSTAGE-1:0] = stat[0];
            ADDR_HIGH_ST: reg_rdata[NSTAGE-1:0] = stat[1];
            ADDR_DONE_ST: reg_rdata[NSTAGE-1:0] = stat[2];
            ADDR_GPIO_ST: reg_rdata[0]          = gpio_stat;
            default: ;
        endcase
    end

    always_comb begin
        pending = gpio_stat;
        for (int c = 0; c < NCLASS; c++) begin
            pending = pending | (|(stat[c] & en[c]));
        end
        int_out = ctrl.pol ? pending : ~pending;
    end

endmodule

// File: rtl/stint_irq_chk.sv
module stint_irq_chk
    import stint_pkg::*;
#(
    parameter int NSTAGE = 12,
    parameter int DW     = 16
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           reg_rd,
    input logic [REG_AW-1:0]              reg_addr,
    input logic [DW-1:0]                  reg_rdata,
    input logic [NSTAGE-1:0]              lim_low,
    input logic [NSTAGE-1:0]              conv_done,
    input logic [NCLASS-1:0][NSTAGE-1:0]  stat,
    input logic                           gpio_oe,
    input logic                           gpio_out
);

    logic rd_low, rd_done, rd_en;
    assign rd_low  = reg_rd && (reg_addr == ADDR_LOW_ST);
    assign rd_done = reg_rd && (reg_addr == ADDR_DONE_ST);
    assign rd_en   = reg_rd && ((reg_addr == ADDR_LOW_EN) || (reg_addr == ADDR_HIGH_EN)
                                || (reg_addr == ADDR_DONE_EN));

    // R2: upper enable bits read as zero
    a_r2_en_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |-> (reg_rdata[DW-1:NSTAGE] == '0));

    // R3: set low-limit bits survive while their register is not read
    a_r3_low_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_low |=> ((stat[0] & $past(stat[0])) == $past(stat[0])));

    // R4: a limit still exceeded keeps its bit, whatever the read does
    a_r4_still_exceeded: assert property (@(posedge clk) disable iff (!rst_n)
        (lim_low != '0) |=> ((stat[0] & $past(lim_low)) == $past(lim_low)));

    // R4: a read drops every bit whose limit was not exceeded in that cycle
    a_r4_read_clears: assert property (@(posedge clk) disable iff (!rst_n)
        rd_low |=> ((stat[0] & ~$past(lim_low)) == '0));

    // R5: completion read clears all but same-cycle pulses
    a_r5_done_clear: assert property (@(posedge clk) disable iff (!rst_n)
        rd_done |=> (stat[2] == $past(conv_done)));

    // R8: the pin output level is high only while driven
    a_r8_out_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !gpio_oe |-> !gpio_out);

endmodule

bind stint_irq_ctrl stint_irq_chk #(.NSTAGE(NSTAGE), .DW(DW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .reg_rd    (reg_rd),
    .reg_addr  (reg_addr),
    .reg_rdata (reg_rdata),
    .lim_low   (lim_low),
    .conv_done (conv_done),
    .stat      (stat),
    .gpio_oe   (gpio_oe),
    .gpio_out  (gpio_out)
);

// File: tb/sim_stint_irq_ctrl.sv
module sim_stint_irq_ctrl;

    localparam int PERIOD = 10;
    localparam int NS     = 12;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [NS-1:0] lim_low = '0, lim_high = '0, conv_done = '0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [2:0]    reg_addr = '0;
    logic [15:0]   reg_wdata = '0;
    logic [15:0]   reg_rdata;
    logic          gpio_in = 1'b0;
    logic          gpio_oe, gpio_out, int_out;

    int n_chk = 0;
    int n_bad = 0;

    always #(PERIOD/2) clk = ~clk;

    stint_irq_ctrl u0 (
        .clk(clk), .rst_n(rst_n), .lim_low(lim_low), .lim_high(lim_high),
        .conv_done(conv_done), .reg_wr(reg_wr), .reg_rd(reg_rd),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .gpio_in(gpio_in), .gpio_oe(gpio_oe), .gpio_out(gpio_out),
        .int_out(int_out)
    );

    task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: got %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [15:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [15:0] d);
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = a;
        #1 d = reg_rdata;
        @(negedge clk);
        reg_rd = 1'b0;
        #1;
    endtask

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic t_reset;
        logic [15:0] d;
        #1;
        check("R1 int idle", {15'd0, int_out}, 16'h0001);
        check("R1 pin off", {15'd0, gpio_oe}, 16'h0000);
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), d);
            check("R1 reg zero", d, 16'h0000);
        end
    endtask

    task automatic t_enables;
        logic [15:0] d;
        wr(3'd1, 16'hFFFF); rd(3'd1, d); check("R2 low en", d, 16'h0FFF);
        wr(3'd2, 16'hA5A5); rd(3'd2, d); check("R2 high en", d, 16'h05A5);
        wr(3'd3, 16'h1234); rd(3'd3, d); check("R2 done en", d, 16'h0234);
        wr(3'd1, 16'h0); wr(3'd2, 16'h0); wr(3'd3, 16'h0);
    endtask

    task automatic t_threshold;
        logic [15:0] d;
        @(negedge clk); lim_low[3] = 1'b1;
        @(negedge clk); lim_low[3] = 1'b0;
        wait_cyc(2);
        rd(3'd4, d); check("R3 low sticky", d, 16'h0008);
        rd(3'd4, d); check("R4 low cleared", d, 16'h0000);
        @(negedge clk); lim_high[5] = 1'b1;
        rd(3'd5, d); check("R4 high held 1", d, 16'h0020);
        rd(3'd5, d); check("R4 high held 2", d, 16'h0020);
        @(negedge clk); lim_high[5] = 1'b0;
        rd(3'd5, d); check("R3 high sticky", d, 16'h0020);
        rd(3'd5, d); check("R4 high cleared", d, 16'h0000);
    endtask

    task automatic t_done;
        logic [15:0] d;
        @(negedge clk); conv_done[11] = 1'b1;
        @(negedge clk); conv_done[11] = 1'b0;
        rd(3'd6, d); check("R5 done set", d, 16'h0800);
        rd(3'd6, d); check("R5 done cleared", d, 16'h0000);
        @(negedge clk); conv_done[2] = 1'b1;
        @(negedge clk); conv_done[2] = 1'b0;
        // pulse stage 0 in the same cycle as the clearing read
        @(negedge clk);
        reg_rd = 1'b1; reg_addr = 3'd6; conv_done[0] = 1'b1;
        #1 d = reg_rdata;
        check("R5 before clear", d, 16'h0004);
        @(negedge clk);
        reg_rd = 1'b0; conv_done[0] = 1'b0;
        rd(3'd6, d); check("R5 event wins", d, 16'h0001);
    endtask

    task automatic t_mask;
        logic [15:0] d;
        @(negedge clk); conv_done[1] = 1'b1;
        @(negedge clk); conv_done[1] = 1'b0;
        #1 check("R6 masked no int", {15'd0, int_out}, 16'h0001);
        rd(3'd6, d); check("R6 masked status", d, 16'h0002);
        wr(3'd3, 16'h0002);
        @(negedge clk); conv_done[1] = 1'b1;
        @(negedge clk); conv_done[1] = 1'b0;
        #1 check("R6 enabled int", {15'd0, int_out}, 16'h0000);
        rd(3'd6, d);
        check("R6 int released", {15'd0, int_out}, 16'h0001);
        wr(3'd3, 16'h0000);
    endtask

    task automatic t_polarity;
        logic [15:0] d;
        wr(3'd0, 16'h0001);
        #1 check("R7 idle high pol", {15'd0, int_out}, 16'h0000);
        rd(3'd0, d); check("R10 ctrl pol", d, 16'h0001);
        wr(3'd2, 16'h0001);
        @(negedge clk); lim_high[0] = 1'b1;
        @(negedge clk); lim_high[0] = 1'b0;
        #1 check("R7 active high", {15'd0, int_out}, 16'h0001);
        rd(3'd5, d);
        check("R7 released", {15'd0, int_out}, 16'h0000);
        wr(3'd0, 16'h0000); wr(3'd2, 16'h0000);
    endtask

    task automatic t_gpio_modes;
        logic [15:0] d;
        wr(3'd0, 16'h0008); #1;
        check("R8 drive low", {14'd0, gpio_oe, gpio_out}, 16'h0002);
        wr(3'd0, 16'h000C); #1;
        check("R8 drive high", {14'd0, gpio_oe, gpio_out}, 16'h0003);
        rd(3'd0, d); check("R10 ctrl mode", d, 16'h000C);
        wr(3'd0, 16'h0004); #1;
        check("R8 input", {14'd0, gpio_oe, gpio_out}, 16'h0000);
        wr(3'd0, 16'h0000); #1;
        check("R8 off", {14'd0, gpio_oe, gpio_out}, 16'h0000);
    endtask

    task automatic t_gpio_int;
        logic [15:0] d;
        gpio_in = 1'b0;
        wr(3'd0, 16'h0014);
        wait_cyc(4);
        check("R9 high trig idle", {15'd0, int_out}, 16'h0001);
        gpio_in = 1'b1; wait_cyc(4);
        check("R9 high trig int", {15'd0, int_out}, 16'h0000);
        rd(3'd7, d); check("R9 status", d, 16'h0001);
        rd(3'd7, d); check("R9 held by level", d, 16'h0001);
        gpio_in = 1'b0; wait_cyc(4);
        rd(3'd7, d); check("R9 sticky", d, 16'h0001);
        check("R9 released", {15'd0, int_out}, 16'h0001);
        rd(3'd7, d); check("R9 cleared", d, 16'h0000);
        wr(3'd0, 16'h0024);
        wait_cyc(4);
        check("R9 low trig int", {15'd0, int_out}, 16'h0000);
        rd(3'd0, d); check("R10 ctrl trig", d, 16'h0024);
        gpio_in = 1'b1; wait_cyc(4);
        rd(3'd7, d); check("R9 low status", d, 16'h0001);
        rd(3'd7, d); check("R9 low cleared", d, 16'h0000);
        wr(3'd0, 16'h0004);
        gpio_in = 1'b0; wait_cyc(4);
        check("R9 no trig", {15'd0, int_out}, 16'h0001);
        rd(3'd7, d); check("R9 no trig status", d, 16'h0000);
        wr(3'd0, 16'h0000);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_enables();
        t_threshold();
        t_done();
        t_mask();
        t_polarity();
        t_gpio_modes();
        t_gpio_int();
        wait_cyc(2);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule